// File: doc/BRIEF.md
# Bitmap Buffer Memory Allocator

This block hands out regions of a 16 KiB shared buffer memory. The memory is cut into equal blocks, and each block has one bit in an occupancy bitmap held as 32-bit map words. An allocate request carries a byte size. The block searches the bitmap for a free, naturally aligned run and returns the byte offset of that run. If no run fits, it returns an out-of-memory code. A free request carries an offset and a size and releases the matching blocks.

The search probes one candidate slot per clock cycle, and `busy` is high while it runs. Candidates sit at a power-of-two stride that covers the request, so an allocation never crosses a map word. Every response is a one-cycle `done` pulse, with `rsp_offset` valid in the same cycle. A synchronous `clr` input empties the whole map.

Top module: `buf_bitmap_alloc`

## Requirements
- R1: The managed memory is MEM_BYTES = 16384 bytes and the block size is MEM_BYTES/32/MAP_WORDS. The defaults are 2 map words, 256-byte blocks and 64 blocks. A successful allocation returns the block index times the block size, where block index = 32*word + bit.
- R2: An allocation of S bytes occupies ceil(S/block size) contiguous blocks. Those blocks are not handed out again until they are freed or the map is cleared.
- R3: The candidate stride is the smallest power of two from 1 to 32 blocks that is at least the block count. Within a word, candidates start at bit 0 and advance by the stride, so every result is a multiple of stride times the block size.
- R4: The search is first fit. Words are tried in ascending order and positions within a word in ascending order. The first candidate whose bits are all clear is taken.
- R5: An allocation with size 0, or one needing more than 32 blocks, returns the code 16384. Its `done` pulse comes one cycle after acceptance, and `busy` never rises.
- R6: When no candidate is free, an allocation returns 16384 after every candidate has been probed.
- R7: A free request (`req_free`=1) sets idx = offset/block size. It clears ceil(size/block size) bits starting at bit idx mod 32 of word idx/32. Its `done` pulse comes one cycle after acceptance, with `rsp_offset` = idx times the block size. A free of size 0 releases nothing.
- R8: One candidate is probed per cycle. An accepted allocation whose search ends after probing n candidates gives `done` n+1 cycles after the accepting edge. `busy` is high from the cycle after acceptance until `done`.
- R9: A request presented while `busy` is high is ignored and does not change the map.
- R10: `clr` zeroes every map word and aborts any search without a `done` pulse. It has priority over a request in the same cycle.
- R11: After reset, `busy` and `done` are low and the map is empty. `done` is a single-cycle pulse and is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous wipe of the whole map |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_free | input | 1 | 1 = free, 0 = allocate |
| req_size | input | 16 | Request size in bytes |
| req_offset | input | 15 | Byte offset of the region to free |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle response pulse |
| rsp_offset | output | 15 | Result offset, or 16384 for out of memory |

## Verification
A corrupted bitmap bit shows up on the next allocation that reaches that slot. It appears either as an offset that overlaps a live region or as a skipped free slot, so `rsp_offset` and the response latency both differ from an independent first-fit model. A wrong stride or a wrong word advance shows up as a misaligned offset or a probe count that disagrees with n+1 cycles. The bench fills the memory repeatedly, for every stride class, until it runs out, so any such fault appears within one fill sweep.

// File: rtl/buf_alloc_pkg.sv
package buf_alloc_pkg;
   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_SEARCH = 1'b1
   } alloc_state_e;

   localparam int unsigned WORD_BITS = 32;
   localparam int unsigned POS_W     = 5;
endpackage

// File: rtl/buf_alloc_sizer.sv
module buf_alloc_sizer #(
   parameter int unsigned SIZE_W = 16,
   parameter int unsigned BLK_LG = 8
) (
   input  logic [SIZE_W-1:0] size,
   output logic [SIZE_W:0]   blocks,
   output logic [5:0]        stride,
   output logic              fits,
   output logic [31:0]       run_mask
);
   localparam logic [SIZE_W:0] BLK_ROUND = (SIZE_W+1)'((1 << BLK_LG) - 1);

   logic [SIZE_W:0] padded;
   logic [5:0]      run_len;
   logic [32:0]     run_wide;

   assign padded = {1'b0, size} + BLK_ROUND;
   assign blocks = padded >> BLK_LG;
   assign fits   = (size != '0) && (blocks <= (SIZE_W+1)'(32));

   always_comb begin
      stride = 6'd32;
      for (int k = 5; k >= 0; k--) begin
         if (((SIZE_W+1)'(1) << k) >= blocks) stride = 6'(1) << k;
      end
   end

   assign run_len  = (blocks > (SIZE_W+1)'(32)) ? 6'd32 : blocks[5:0];
   assign run_wide = (33'(1) << run_len) - 33'd1;
   assign run_mask = run_wide[31:0];
endmodule

// File: rtl/buf_alloc_bitmap.sv
module buf_alloc_bitmap #(
   parameter int unsigned MAP_WORDS = 2,
   parameter int unsigned WORD_W    = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wipe,
   input  logic                    set_en,
   input  logic [WORD_W-1:0]       set_word,
   input  logic [31:0]             set_mask,
   input  logic                    rel_en,
   input  logic [WORD_W-1:0]       rel_word,
   input  logic [31:0]             rel_mask,
   output logic [MAP_WORDS*32-1:0] map_bits
);
   for (genvar w = 0; w < MAP_WORDS; w++) begin : g_word
      logic [31:0] word_q;
      logic [31:0] set_m, rel_m;

      assign set_m = (set_en && int'(set_word) == w) ? set_mask : '0;
      assign rel_m = (rel_en && int'(rel_word) == w) ? rel_mask : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    word_q <= '0;
         else if (wipe) word_q <= '0;
         else           word_q <= (word_q | set_m) & ~rel_m;
      end

      assign map_bits[w*32 +: 32] = word_q;
   end
endmodule

// File: rtl/buf_alloc_probe.sv
module buf_alloc_probe (
   input  logic [31:0] word_bits,
   input  logic [4:0]  pos,
   input  logic [31:0] run_mask,
   input  logic [5:0]  stride,
   output logic        hit,
   output logic [31:0] cand_mask,
   output logic        wrap,
   output logic [4:0]  next_pos
);
   logic [5:0] pos_sum;

   assign cand_mask = run_mask << pos;
   assign hit       = (word_bits & cand_mask) == '0;
   assign pos_sum   = {1'b0, pos} + stride;
   assign wrap      = pos_sum[5];
   assign next_pos  = pos_sum[4:0];
endmodule

// File: rtl/buf_bitmap_alloc.sv
module buf_bitmap_alloc #(
   parameter int unsigned MEM_BYTES = 16384,
   parameter int unsigned MAP_WORDS = 2,
   parameter int unsigned SIZE_W    = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          req_valid,
   input  logic                          req_free,
   input  logic [SIZE_W-1:0]             req_size,
   input  logic [$clog2(MEM_BYTES):0]    req_offset,
   output logic                          busy,
   output logic                          done,
   output logic [$clog2(MEM_BYTES):0]    rsp_offset
);
   import buf_alloc_pkg::*;

   localparam int unsigned BLK_BYTES = MEM_BYTES / 32 / MAP_WORDS;
   localparam int unsigned BLK_LG    = $clog2(BLK_BYTES);
   localparam int unsigned OFF_W     = $clog2(MEM_BYTES) + 1;
   localparam int unsigned WORD_W    = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1;
   localparam logic [OFF_W-1:0] OOM  = OFF_W'(MEM_BYTES);

   if ((MEM_BYTES & (MEM_BYTES - 1)) != 0 || (MAP_WORDS & (MAP_WORDS - 1)) != 0)
      begin : g_bad_pow2
         $error("MEM_BYTES and MAP_WORDS must be powers of two");
      end
   if (BLK_BYTES < 1 || MEM_BYTES < 32 * MAP_WORDS) begin : g_bad_blk
      $error("block size must be at least one byte");
   end
   if (SIZE_W < OFF_W) begin : g_bad_size
      $error("SIZE_W must cover the memory size");
   end

   alloc_state_e        state_q;
   logic [WORD_W-1:0]   word_q;
   logic [POS_W-1:0]    pos_q;
   logic [31:0]         run_q;
   logic [5:0]          stride_q;
   logic                done_q;
   logic [OFF_W-1:0]    off_q;

   logic [SIZE_W:0]     req_blocks;
   logic [5:0]          req_stride;
   logic                req_fits;
   logic [31:0]         req_run;

   logic [MAP_WORDS*32-1:0] map_bits;
   logic [31:0]         cur_word_bits;
   logic                hit, wrap;
   logic [31:0]         cand_mask;
   logic [4:0]          next_pos;

   logic                accept, set_en, rel_en, last_word;
   logic [OFF_W-1:0]    rel_idx, hit_idx;
   logic [OFF_W-1:0]    rel_word_full;
   logic [31:0]         rel_mask;

   buf_alloc_sizer #(.SIZE_W(SIZE_W), .BLK_LG(BLK_LG)) u_sizer (
      .size     (req_size),
      .blocks   (req_blocks),
      .stride   (req_stride),
      .fits     (req_fits),
      .run_mask (req_run)
   );

   assign cur_word_bits = map_bits[word_q*32 +: 32];

   buf_alloc_probe u_probe (
      .word_bits (cur_word_bits),
      .pos       (pos_q),
      .run_mask  (run_q),
      .stride    (stride_q),
      .hit       (hit),
      .cand_mask (cand_mask),
      .wrap      (wrap),
      .next_pos  (next_pos)
   );

   assign accept        = (state_q == ST_IDLE) && req_valid && !clr;
   assign rel_idx       = req_offset >> BLK_LG;
   assign rel_word_full = rel_idx >> 5;
   assign rel_mask      = req_run << rel_idx[4:0];
   assign rel_en        = accept && req_free && (rel_word_full < OFF_W'(MAP_WORDS));
   assign set_en        = (state_q == ST_SEARCH) && hit && !clr;
   assign last_word     = (word_q == WORD_W'(MAP_WORDS - 1));
   assign hit_idx       = OFF_W'(word_q) * OFF_W'(32) + OFF_W'(pos_q);

   buf_alloc_bitmap #(.MAP_WORDS(MAP_WORDS), .WORD_W(WORD_W)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .wipe     (clr),
      .set_en   (set_en),
      .set_word (word_q),
      .set_mask (cand_mask),
      .rel_en   (rel_en),
      .rel_word (WORD_W'(rel_word_full)),
      .rel_mask (rel_mask),
      .map_bits (map_bits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         word_q   <= '0;
         pos_q    <= '0;
         run_q    <= '0;
         stride_q <= 6'd1;
         done_q   <= 1'b0;
         off_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (clr) begin
            state_q <= ST_IDLE;
         end else if (state_q == ST_IDLE) begin
            if (req_valid) begin
               if (req_free) begin
                  done_q <= 1'b1;
                  off_q  <= rel_idx << BLK_LG;
               end else if (req_fits) begin
                  state_q  <= ST_SEARCH;
                  word_q   <= '0;
                  pos_q    <= '0;
                  run_q    <= req_run;
                  stride_q <= req_stride;
               end else begin
                  done_q <= 1'b1;
                  off_q  <= OOM;
               end
            end
         end else begin
            if (hit) begin
               done_q  <= 1'b1;
               off_q   <= hit_idx << BLK_LG;
               state_q <= ST_IDLE;
            end else if (wrap) begin
               if (last_word) begin
                  done_q  <= 1'b1;
                  off_q   <= OOM;
                  state_q <= ST_IDLE;
               end else begin
                  word_q <= word_q + WORD_W'(1);
                  pos_q  <= '0;
               end
            end else begin
               pos_q <= next_pos;
            end
         end
      end
   end

   assign busy       = (state_q == ST_SEARCH);
   assign done       = done_q;
   assign rsp_offset = off_q;
endmodule

// File: rtl/buf_bitmap_alloc_chk.sv
module buf_bitmap_alloc_chk #(
   parameter int unsigned MEM_BYTES = 16384,
   parameter int unsigned MAP_WORDS = 2,
   parameter int unsigned SIZE_W    = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       clr,
   input logic                       req_valid,
   input logic                       req_free,
   input logic [SIZE_W-1:0]          req_size,
   input logic [$clog2(MEM_BYTES):0] req_offset,
   input logic                       busy,
   input logic                       done,
   input logic [$clog2(MEM_BYTES):0] rsp_offset
);
   localparam int unsigned BLK_BYTES = MEM_BYTES / 32 / MAP_WORDS;
   localparam int unsigned BLK_LG    = $clog2(BLK_BYTES);
   localparam int unsigned OFF_W     = $clog2(MEM_BYTES) + 1;
   localparam logic [OFF_W-1:0] OOM  = OFF_W'(MEM_BYTES);
   localparam logic [SIZE_W:0] MAX_BYTES = (SIZE_W+1)'(32 * BLK_BYTES);

   logic idle_alloc;
   assign idle_alloc = req_valid && !busy && !clr && !req_free;

   // R11
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R1
   offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rsp_offset <= OOM));

   // R3
   offset_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rsp_offset != OOM) |-> (rsp_offset[BLK_LG-1:0] == '0));

   // R5
   bad_size_oom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_alloc && (req_size == '0 || {1'b0, req_size} > MAX_BYTES))
      |=> (done && rsp_offset == OOM && !busy));

   // R8
   search_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_alloc && req_size != '0 && {1'b0, req_size} <= MAX_BYTES)
      |=> (busy && !done));

   // R7
   free_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && !clr && req_free) |=> (done && !busy));

   // R10
   clear_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!busy && !done));

   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || $past(clr)));
endmodule

bind buf_bitmap_alloc buf_bitmap_alloc_chk #(
   .MEM_BYTES (MEM_BYTES),
   .MAP_WORDS (MAP_WORDS),
   .SIZE_W    (SIZE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr        (clr),
   .req_valid  (req_valid),
   .req_free   (req_free),
   .req_size   (req_size),
   .req_offset (req_offset),
   .busy       (busy),
   .done       (done),
   .rsp_offset (rsp_offset)
);

// File: tb/sim_buf_bitmap_alloc.sv
module sim_buf_bitmap_alloc;
   localparam int OOM = 16384;
   localparam int BLK = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_free = 1'b0;
   logic [15:0] req_size = '0;
   logic [14:0] req_offset = '0;
   logic        busy, done;
   logic [14:0] rsp_offset;

   int n_chk = 0;
   int n_fail = 0;
   bit mdl [64];

   always #2 clk = ~clk;

   buf_bitmap_alloc u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .req_valid(req_valid),
      .req_free(req_free), .req_size(req_size), .req_offset(req_offset),
      .busy(busy), .done(done), .rsp_offset(rsp_offset)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // first-fit reference from R1-style arithmetic: stride, word order, bit order
   task automatic model_alloc(input int size, output int off, output int probes);
      int nb, st;
      nb = (size + BLK - 1) / BLK;
      off = OOM;
      probes = 0;
      if (size == 0 || nb > 32) return;
      st = 1;
      while (st < nb) st = st * 2;
      for (int w = 0; w < 2; w++) begin
         for (int p = 0; p < 32; p += st) begin
            bit clear_ok;
            probes++;
            clear_ok = 1'b1;
            for (int b = 0; b < nb; b++) if (mdl[w*32+p+b]) clear_ok = 1'b0;
            if (clear_ok) begin
               for (int b = 0; b < nb; b++) mdl[w*32+p+b] = 1'b1;
               off = (w*32+p) * BLK;
               return;
            end
         end
      end
   endtask

   task automatic wait_done(output int lat);
      lat = 1;
      while (!done && lat < 300) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic alloc_op(input int size, input string req, output int got);
      int eo, ep, lat;
      model_alloc(size, eo, ep);
      req_valid = 1'b1; req_free = 1'b0; req_size = 16'(size);
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(lat);
      got = int'(rsp_offset);
      chk(done && rsp_offset == 15'(eo), req, int'(rsp_offset), eo);
      chk(lat == ep + 1, "R8 latency", lat, ep + 1);
      @(negedge clk);
   endtask

   task automatic free_op(input int off, input int size);
      int lat, nb, idx;
      idx = off / BLK;
      nb = (size + BLK - 1) / BLK;
      for (int b = 0; b < nb && (idx % 32) + b < 32; b++) mdl[idx+b] = 1'b0;
      req_valid = 1'b1; req_free = 1'b1; req_size = 16'(size); req_offset = 15'(off);
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(lat);
      chk(done && lat == 1 && rsp_offset == 15'(idx*BLK), "R7 free response",
          int'(rsp_offset), idx*BLK);
      @(negedge clk);
   endtask

   task automatic wipe();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      foreach (mdl[i]) mdl[i] = 1'b0;
      chk(!busy && !done, "R10 clear idle", int'(busy), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual expired expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int got, lat;
      int sizes [13] = '{1, 256, 257, 512, 513, 768, 1024, 1025, 2048, 3000, 4096, 5000, 8192};
      foreach (mdl[i]) mdl[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done, "R11 reset state", int'(busy) + int'(done), 0);

      // R5 rejected sizes
      alloc_op(0, "R5 zero size", got);
      alloc_op(8193, "R5 oversize", got);
      alloc_op(65535, "R5 max size", got);

      // R2 R3 R4 R6 sweep: fill until full for each stride class
      foreach (sizes[s]) begin
         int cnt;
         wipe();
         cnt = 0;
         got = 0;
         while (got != OOM && cnt < 70) begin
            alloc_op(sizes[s], "R4 fill sweep", got);
            cnt++;
         end
         chk(got == OOM, "R6 exhausted", got, OOM);
      end

      // R1 geometry: first 256-byte allocations at block multiples
      wipe();
      alloc_op(256, "R1 first block", got);
      chk(got == 0, "R1 offset zero", got, 0);
      alloc_op(300, "R3 stride two", got);
      chk(got == 512, "R3 aligned pair", got, 512);
      alloc_op(256, "R4 back fill", got);
      chk(got == 256, "R4 gap reuse", got, 256);
      alloc_op(8192, "R3 full word", got);
      chk(got == 8192, "R3 next word", got, 8192);
      free_op(512, 300);
      alloc_op(600, "R2 realloc freed", got);
      free_op(0, 0);
      alloc_op(256, "R7 zero free kept", got);
      free_op(8192, 8192);
      alloc_op(8192, "R7 word freed", got);
      chk(got == 8192, "R7 word freed offset", got, 8192);

      // R9: request while busy ignored
      wipe();
      for (int i = 0; i < 63; i++) alloc_op(256, "R9 prefill", got);
      model_alloc(256, got, lat);
      req_valid = 1'b1; req_free = 1'b0; req_size = 16'd256;
      @(negedge clk);
      req_free = 1'b1; req_offset = 15'd0; req_size = 16'd256;
      repeat (4) @(negedge clk);
      req_valid = 1'b0;
      while (!done) @(negedge clk);
      chk(rsp_offset == 15'(63*BLK), "R9 search result", int'(rsp_offset), 63*BLK);
      @(negedge clk);
      alloc_op(256, "R9 ignored free", got);
      chk(got == OOM, "R9 map unchanged", got, OOM);

      // R10: clear aborts a long search
      req_valid = 1'b1; req_free = 1'b0; req_size = 16'd256;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk(busy, "R10 searching", int'(busy), 1);
      clr = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      clr = 1'b0; req_valid = 1'b0;
      foreach (mdl[i]) mdl[i] = 1'b0;
      chk(!busy && !done, "R10 aborted", int'(busy) + int'(done), 0);
      repeat (3) begin
         chk(!done, "R10 no done", int'(done), 0);
         @(negedge clk);
      end
      alloc_op(256, "R10 map wiped", got);
      chk(got == 0, "R10 wiped offset", got, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule